// File: doc/BRIEF.md
# Byte-Wide Four-Register Sequencer Core

A small 8-bit processor. It has four 8-bit general registers, an 8-bit program counter and one 256-byte memory that holds both code and data. Each instruction is a single byte. The two immediate forms also take the byte that follows the instruction. Instructions run one at a time over several clock cycles. The core stops for good, with its program counter frozen, when it fetches a byte whose top bit is set.

A program is loaded through a byte-wide write port while the core is held in reset. The port uses a valid/ready handshake. `pl_ready` is high exactly while `rst` is high, and a byte is written in a cycle where both `pl_valid` and `pl_ready` are high. Outside reset the port applies back-pressure by holding `pl_ready` low, and any offered byte is neither written nor dropped into a buffer. After reset is released the core runs from address 0. The PC, the flattened register file and a halted flag are always visible. A combinational debug port reads any memory byte.

Instruction byte layout: bit 7 = stop bit, bits 6..4 = operation, bits 3..2 = register A index, bits 1..0 = register B index or sub-operation. rA and rB denote the registers selected by those fields.

Top module: `byte_core`

## Requirements
- R1: While `rst` is high the PC, all four registers and `halted` read 0 one clock later. Memory contents are not cleared by reset.
- R2: A fetched byte with bit 7 set changes no register or memory. The PC keeps its value, and `halted` goes high one cycle after the fetch and stays high until reset (00 00 00 80 halts with PC 3).
- R3: Operation 0 copies rB into rA, operation 1 adds rB into rA and operation 2 ANDs rB into rA. Each then advances the PC by 1.
- R4: Operation 3 loads rA from memory at address rB, and operation 4 writes rA to memory at address rB. Each advances the PC by 1.
- R5: Operation 5 acts on rA according to the B field. 0 gives the bitwise inverse, 1 gives the two's-complement negation, 2 gives 1 if rA was zero and 0 otherwise, and 3 gives the address of the instruction itself.
- R6: Operation 6 reads the byte at PC+1. The B field selects the action: 0 loads it into rA, 1 adds it into rA, 2 ANDs it into rA, and 3 loads rA from memory at that address. The PC then advances by 2.
- R7: Operation 7 reads rA as a signed byte. When rA <= 0 (0x00 or 0x80..0xFF) the PC is loaded from rB, otherwise the PC advances by 1.
- R8: Operations 0, 1, 2, 5 and 7 take 2 cycles. Operations 3 and 4, and operation 6 with B of 0..2, take 3 cycles. Operation 6 with B=3 takes 4 cycles. The PC and registers change together at the last cycle of the instruction.
- R9: Arithmetic wraps modulo 256, and PC+1 and PC+2 wrap within the 256-byte address space.
- R10: `dbg_data` shows the memory byte at `dbg_addr` combinationally.
- R11: A preload byte is written only when `pl_valid` and `pl_ready` are both high, and `pl_ready` is high only during reset. A byte offered while the core runs changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the preload port |
| pl_valid | input | 1 | Preload byte offered |
| pl_ready | output | 1 | Preload byte can be accepted (high during reset) |
| pl_addr | input | 8 | Preload target address |
| pl_data | input | 8 | Preload byte |
| dbg_addr | input | 8 | Debug memory read address |
| dbg_data | output | 8 | Memory byte at dbg_addr |
| pc | output | 8 | Program counter |
| regs | output | 32 | Register file, register i in bits 8i+7..8i |
| halted | output | 1 | Core stopped on a stop-bit instruction |

## Verification
The hardest cases to reach from the ports are the address wrap cases: an immediate fetched from address 0 by an instruction at 0xFF, and a PC that rolls past 0xFF into a halt at address 1. A preloaded program reaches them by branching to 0xFF with a zero register and leaving the immediate instruction at the top byte. The branch boundary values 0x80, 0xFF, 0x00, 0x01 and 0x7F each run as their own program. One run also offers preload bytes throughout execution, and the target byte is read back afterwards through the debug port.

// File: rtl/byte_core_pkg.sv
package byte_core_pkg;

  // Instruction field positions (fixed by the instruction set)
  localparam int STOP_BIT  = 7;
  localparam int OPC_MSB   = 6;
  localparam int OPC_LSB   = 4;
  localparam int RA_MSB    = 3;
  localparam int RA_LSB    = 2;
  localparam int RB_MSB    = 1;
  localparam int RB_LSB    = 0;
  localparam int IDX_W     = RA_MSB - RA_LSB + 1;
  localparam int OPC_W     = OPC_MSB - OPC_LSB + 1;
  localparam int BODY_W    = OPC_MSB + 1;

  typedef enum logic [OPC_W-1:0] {
    OP_MOV   = 3'd0,
    OP_ADD   = 3'd1,
    OP_AND   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4,
    OP_UNARY = 3'd5,
    OP_IMM   = 3'd6,
    OP_BLEZ  = 3'd7
  } opcode_t;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_IMM,
    ST_MEM,
    ST_EXEC,
    ST_HALT
  } core_state_t;

  // sub-operation selector values
  localparam logic [1:0] SUB_0 = 2'd0;
  localparam logic [1:0] SUB_1 = 2'd1;
  localparam logic [1:0] SUB_2 = 2'd2;
  localparam logic [1:0] SUB_3 = 2'd3;

endpackage

// File: rtl/byte_core_mem.sv
module byte_core_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // contents deliberately have no reset: a preloaded program must survive it
  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data_a = cells[rd_addr_a];
  assign rd_data_b = cells[rd_addr_b];

endmodule

// File: rtl/byte_core_regfile.sv
module byte_core_regfile #(
  parameter int WORD_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [WORD_W-1:0]             wr_val,
  input  logic [SEL_W-1:0]              rd_sel_a,
  output logic [WORD_W-1:0]             rd_val_a,
  input  logic [SEL_W-1:0]              rd_sel_b,
  output logic [WORD_W-1:0]             rd_val_b,
  output logic [(WORD_W<<SEL_W)-1:0]    all_regs
);
  localparam int NREG = 1 << SEL_W;

  logic [WORD_W-1:0] bank_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (wr_en) begin
      bank_q[wr_sel] <= wr_val;
    end
  end

  assign rd_val_a = bank_q[rd_sel_a];
  assign rd_val_b = bank_q[rd_sel_b];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign all_regs[g*WORD_W +: WORD_W] = bank_q[g];
  end

endmodule

// File: rtl/byte_core_alu.sv
module byte_core_alu
  import byte_core_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  opcode_t           op,
  input  logic [1:0]        sub,
  input  logic [WORD_W-1:0] a_val,
  input  logic [WORD_W-1:0] b_val,
  input  logic [WORD_W-1:0] imm_val,
  input  logic [WORD_W-1:0] mdr_val,
  input  logic [WORD_W-1:0] pc_val,
  output logic              wb_en,
  output logic [WORD_W-1:0] wb_val,
  output logic [WORD_W-1:0] next_pc
);
  localparam logic [WORD_W-1:0] STEP1 = WORD_W'(1);
  localparam logic [WORD_W-1:0] STEP2 = WORD_W'(2);

  logic a_not_pos;
  assign a_not_pos = a_val[WORD_W-1] || (a_val == '0);

  always_comb begin
    wb_en   = 1'b1;
    wb_val  = a_val;
    next_pc = pc_val + STEP1;
    unique case (op)
      OP_MOV:   wb_val = b_val;
      OP_ADD:   wb_val = a_val + b_val;
      OP_AND:   wb_val = a_val & b_val;
      OP_LOAD:  wb_val = mdr_val;
      OP_STORE: wb_en  = 1'b0;
      OP_UNARY: begin
        unique case (sub)
          SUB_0:   wb_val = ~a_val;
          SUB_1:   wb_val = '0 - a_val;
          SUB_2:   wb_val = {{(WORD_W-1){1'b0}}, (a_val == '0)};
          default: wb_val = pc_val;
        endcase
      end
      OP_IMM: begin
        next_pc = pc_val + STEP2;
        unique case (sub)
          SUB_0:   wb_val = imm_val;
          SUB_1:   wb_val = a_val + imm_val;
          SUB_2:   wb_val = a_val & imm_val;
          default: wb_val = mdr_val;
        endcase
      end
      default: begin
        wb_en = 1'b0;
        if (a_not_pos) next_pc = b_val;
      end
    endcase
  end

endmodule

// File: rtl/byte_core_ctrl.sv
module byte_core_ctrl
  import byte_core_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [IDX_W-1:0]  ra_idx,
  output logic [IDX_W-1:0]  rb_idx,
  input  logic [WORD_W-1:0] ra_val,
  input  logic [WORD_W-1:0] rb_val,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_widx,
  output logic [WORD_W-1:0] rf_wdata,
  output logic [WORD_W-1:0] pc_o,
  output logic              halted_o
);
  localparam logic [WORD_W-1:0] STEP1 = WORD_W'(1);

  core_state_t       state_q;
  logic [BODY_W-1:0] ir_q;
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] imm_q;
  logic [WORD_W-1:0] mdr_q;

  opcode_t    cur_op;
  logic [1:0] cur_sub;
  opcode_t    fetch_op;
  logic       wb_en;
  logic [WORD_W-1:0] wb_val;
  logic [WORD_W-1:0] next_pc;

  assign cur_op   = opcode_t'(ir_q[OPC_MSB:OPC_LSB]);
  assign cur_sub  = ir_q[RB_MSB:RB_LSB];
  assign fetch_op = opcode_t'(mem_rdata[OPC_MSB:OPC_LSB]);
  assign ra_idx   = ir_q[RA_MSB:RA_LSB];
  assign rb_idx   = ir_q[RB_MSB:RB_LSB];

  // single memory port: instruction, immediate, then data address
  always_comb begin
    unique case (state_q)
      ST_IMM:  mem_addr = pc_q + STEP1;
      ST_MEM:  mem_addr = (cur_op == OP_IMM) ? imm_q : rb_val;
      default: mem_addr = pc_q;
    endcase
  end

  assign mem_we    = (state_q == ST_MEM) && (cur_op == OP_STORE);
  assign mem_wdata = ra_val;

  byte_core_alu #(.WORD_W(WORD_W)) u_alu (
    .op      (cur_op),
    .sub     (cur_sub),
    .a_val   (ra_val),
    .b_val   (rb_val),
    .imm_val (imm_q),
    .mdr_val (mdr_q),
    .pc_val  (pc_q),
    .wb_en   (wb_en),
    .wb_val  (wb_val),
    .next_pc (next_pc)
  );

  assign rf_we    = (state_q == ST_EXEC) && wb_en;
  assign rf_widx  = ra_idx;
  assign rf_wdata = wb_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      imm_q   <= '0;
      mdr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: begin
          ir_q <= mem_rdata[BODY_W-1:0];
          if (mem_rdata[STOP_BIT])                                  state_q <= ST_HALT;
          else if (fetch_op == OP_IMM)                              state_q <= ST_IMM;
          else if (fetch_op == OP_LOAD || fetch_op == OP_STORE)     state_q <= ST_MEM;
          else                                                      state_q <= ST_EXEC;
        end
        ST_IMM: begin
          imm_q   <= mem_rdata;
          state_q <= (cur_sub == SUB_3) ? ST_MEM : ST_EXEC;
        end
        ST_MEM: begin
          mdr_q   <= mem_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          pc_q    <= next_pc;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign halted_o = (state_q == ST_HALT);

  // R1: reset returns the PC to zero and clears the stop flag
  a_r1_reset_clears_pc: assert property (@(posedge clk)
    rst |=> (pc_q == '0) && !halted_o);

  // R2: once stopped, the core stays stopped with a frozen PC
  a_r2_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o && $stable(pc_q));

  // R8: the PC only moves at the writeback cycle
  a_r8_pc_moves_at_exec: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_EXEC) |=> $stable(pc_q));

  // R6: immediate forms step the PC by two, wrapping
  a_r6_imm_step_two: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && cur_op == OP_IMM) |=>
      (pc_q == WORD_W'($past(pc_q) + WORD_W'(2))));

  // R7: a strictly positive rA falls through
  a_r7_positive_falls_through: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && cur_op == OP_BLEZ && !ra_val[WORD_W-1] && ra_val != '0) |=>
      (pc_q == WORD_W'($past(pc_q) + WORD_W'(1))));

endmodule

// File: rtl/byte_core.sv
module byte_core
  import byte_core_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pl_valid,
  output logic                       pl_ready,
  input  logic [WORD_W-1:0]          pl_addr,
  input  logic [WORD_W-1:0]          pl_data,
  input  logic [WORD_W-1:0]          dbg_addr,
  output logic [WORD_W-1:0]          dbg_data,
  output logic [WORD_W-1:0]          pc,
  output logic [(WORD_W<<IDX_W)-1:0] regs,
  output logic                       halted
);
  logic [WORD_W-1:0] core_addr;
  logic              core_we;
  logic [WORD_W-1:0] core_wdata;
  logic [WORD_W-1:0] core_rdata;
  logic              wr_en;
  logic [WORD_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [IDX_W-1:0]  ra_idx, rb_idx, rf_widx;
  logic [WORD_W-1:0] ra_val, rb_val, rf_wdata;
  logic              rf_we;

  // preload owns the write port during reset, the core otherwise
  assign pl_ready = rst;
  assign wr_en    = pl_ready ? pl_valid : core_we;
  assign wr_addr  = pl_ready ? pl_addr  : core_addr;
  assign wr_data  = pl_ready ? pl_data  : core_wdata;

  byte_core_mem #(.ADDR_W(WORD_W), .DATA_W(WORD_W)) u_mem (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (core_addr),
    .rd_data_a (core_rdata),
    .rd_addr_b (dbg_addr),
    .rd_data_b (dbg_data)
  );

  byte_core_regfile #(.WORD_W(WORD_W), .SEL_W(IDX_W)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rf_we),
    .wr_sel   (rf_widx),
    .wr_val   (rf_wdata),
    .rd_sel_a (ra_idx),
    .rd_val_a (ra_val),
    .rd_sel_b (rb_idx),
    .rd_val_b (rb_val),
    .all_regs (regs)
  );

  byte_core_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (core_rdata),
    .mem_addr  (core_addr),
    .mem_we    (core_we),
    .mem_wdata (core_wdata),
    .ra_idx    (ra_idx),
    .rb_idx    (rb_idx),
    .ra_val    (ra_val),
    .rb_val    (rb_val),
    .rf_we     (rf_we),
    .rf_widx   (rf_widx),
    .rf_wdata  (rf_wdata),
    .pc_o      (pc),
    .halted_o  (halted)
  );

  // R1: registers read zero one cycle after reset
  a_r1_regs_cleared: assert property (@(posedge clk)
    rst |=> (regs == '0));

  // R2: a stopped core writes no register
  a_r2_halt_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(regs));

endmodule

// File: tb/byte_core_test.sv
module byte_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pl_valid = 1'b0;
  logic [7:0]  pl_addr = '0, pl_data = '0, dbg_addr = '0;
  logic        pl_ready, halted;
  logic [7:0]  dbg_data, pc;
  logic [31:0] regs;

  byte_core uut (
    .clk(clk), .rst(rst), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_addr(pl_addr), .pl_data(pl_data), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .pc(pc), .regs(regs), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] img [256];
  logic [7:0] mm  [256];
  logic [7:0] mr  [4];
  logic [7:0] mpc;
  bit         mh;
  int         mcnt;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_code(input logic [255:0] code, input int n);
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    for (int i = 0; i < n; i++) img[i] = code[8*(n-1-i) +: 8];
  endtask

  function automatic int cost(input logic [7:0] ir);
    if (ir[6:4] == 3'd6) return (ir[1:0] == 2'd3) ? 4 : 3;
    if (ir[6:4] == 3'd3 || ir[6:4] == 3'd4) return 3;
    return 2;
  endfunction

  // behavioural reference: one call per rising edge out of reset
  task automatic model_step();
    logic [7:0] ir, imm, nx;
    logic [1:0] a, b;
    if (mh) return;
    ir = mm[mpc];
    mcnt++;
    if (ir[7]) begin
      mh = 1'b1; mcnt = 0; return;
    end
    if (mcnt < cost(ir)) return;
    mcnt = 0;
    a = ir[3:2]; b = ir[1:0];
    nx = mpc + 8'd1;
    case (ir[6:4])
      3'd0: mr[a] = mr[b];
      3'd1: mr[a] = mr[a] + mr[b];
      3'd2: mr[a] = mr[a] & mr[b];
      3'd3: mr[a] = mm[mr[b]];
      3'd4: mm[mr[b]] = mr[a];
      3'd5: case (b)
              2'd0: mr[a] = ~mr[a];
              2'd1: mr[a] = 8'd0 - mr[a];
              2'd2: mr[a] = (mr[a] == 8'd0) ? 8'd1 : 8'd0;
              default: mr[a] = mpc;
            endcase
      3'd6: begin
        imm = mm[8'(mpc + 8'd1)];
        nx  = mpc + 8'd2;
        case (b)
          2'd0: mr[a] = imm;
          2'd1: mr[a] = mr[a] + imm;
          2'd2: mr[a] = mr[a] & imm;
          default: mr[a] = mm[imm];
        endcase
      end
      default: if ($signed(mr[a]) <= 0) nx = mr[b];
    endcase
    mpc = nx;
  endtask

  task automatic run(input int ncyc, input bit junk);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      pl_valid = 1'b1; pl_addr = 8'(i); pl_data = img[i];
      @(negedge clk);
    end
    pl_valid = 1'b0;
    for (int i = 0; i < 256; i++) mm[i] = img[i];
    for (int i = 0; i < 4; i++) mr[i] = 8'h00;
    mpc = 8'h00; mh = 1'b0; mcnt = 0;
    chk("R1", "reset pc", pc, 0);
    chk("R1", "reset regs", regs, 0);
    chk("R1", "reset halted", halted, 0);
    chk("R11", "ready in reset", pl_ready, 1);
    rst = 1'b0;
    if (junk) begin
      pl_valid = 1'b1; pl_addr = 8'h30; pl_data = 8'hAA;
    end
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      model_step();
      chk("R8", "pc lockstep", pc, mpc);
      chk("R8", "regs lockstep", regs, {mr[3], mr[2], mr[1], mr[0]});
      chk("R8", "halted lockstep", halted, mh);
      if (junk) chk("R11", "ready while running", pl_ready, 0);
    end
    pl_valid = 1'b0;
  endtask

  task automatic mem_is(input string tag, input logic [7:0] addr, input logic [7:0] exp);
    dbg_addr = addr;
    #1;
    chk(tag, "memory byte", dbg_data, exp);
  endtask

  task automatic reg_is(input string tag, input int idx, input logic [7:0] exp);
    chk(tag, "register", regs[8*idx +: 8], exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R2 stop bit halts in place
    set_code(32'h00000080, 4); run(20, 0);
    chk("R2", "halt pc", pc, 8'h03); chk("R2", "halted", halted, 1);
    chk("R2", "regs untouched", regs, 0);

    // R4 store via move program, R11 preload refused while running
    set_code(56'h68230660204480, 7); run(40, 1);
    chk("R4", "move regs", regs, 32'h00232320);
    mem_is("R4", 8'h20, 8'h23);
    mem_is("R11", 8'h30, 8'h00);
    mem_is("R10", 8'h00, 8'h68);
    // R1 memory survives a second reset
    @(negedge clk); rst = 1'b1; @(negedge clk);
    chk("R1", "re-reset pc", pc, 0); chk("R1", "re-reset regs", regs, 0);
    mem_is("R1", 8'h20, 8'h23);

    // R4 load + R3 add: math program
    set_code(144'h6810326811361468124680000000000023A1, 18); run(60, 0);
    mem_is("R4", 8'h12, 8'hC4);

    // R3 copy / add / and, R4 load and store
    set_code(32'h64140980, 4); run(20, 0); reg_is("R3", 2, 8'h14);
    set_code(48'h641468201980, 6); run(20, 0); reg_is("R3", 2, 8'h34);
    set_code(48'h641468202980, 6); run(20, 0); reg_is("R3", 2, 8'h00);
    set_code(32'h64023980, 4); run(20, 0); reg_is("R4", 2, 8'h39);
    set_code(48'h640268204680, 6); run(20, 0); mem_is("R4", 8'h20, 8'h02);

    // R5 unary forms
    set_code(32'h64895480, 4); run(20, 0); reg_is("R5", 1, 8'h76);
    set_code(32'h64895580, 4); run(20, 0); reg_is("R5", 1, 8'h77);
    set_code(32'h64895680, 4); run(20, 0); reg_is("R5", 1, 8'h00);
    set_code(16'h5680, 2);     run(20, 0); reg_is("R5", 1, 8'h01);
    set_code(32'h64895780, 4); run(20, 0); reg_is("R5", 1, 8'h02);

    // R6 immediate forms
    set_code(40'h6414642080, 5); run(20, 0); reg_is("R6", 1, 8'h20);
    set_code(40'h6414652080, 5); run(20, 0); reg_is("R6", 1, 8'h34);
    set_code(40'h6414662480, 5); run(20, 0); reg_is("R6", 1, 8'h04);
    set_code(40'h6414670280, 5); run(20, 0); reg_is("R6", 1, 8'h67);
    set_code(64'h680A6C144E670A80, 8); run(40, 0);
    reg_is("R6", 1, 8'h14); mem_is("R4", 8'h0A, 8'h14);

    // R9 wrap of add and of PC
    set_code(40'h64F0652080, 5); run(20, 0); reg_is("R9", 1, 8'h10);
    set_code(24'h64FF71, 3); img[255] = 8'h64; run(40, 0);
    chk("R9", "wrapped pc", pc, 8'h01); reg_is("R9", 1, 8'h64);
    chk("R9", "halted after wrap", halted, 1);

    // R7 branch examples
    set_code(48'h600A64147180, 6); img[8'h14] = 8'h80; run(30, 0);
    chk("R7", "positive no branch", pc, 8'h05);
    set_code(48'h60F664147180, 6); img[8'h14] = 8'h80; run(30, 0);
    chk("R7", "negative branch", pc, 8'h14);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] v, want;
      case (k)
        0: begin v = 8'hFF; want = 8'h14; end
        1: begin v = 8'h80; want = 8'h14; end
        2: begin v = 8'h00; want = 8'h14; end
        3: begin v = 8'h01; want = 8'h05; end
        default: begin v = 8'h7F; want = 8'h05; end
      endcase
      set_code({8'h64, 8'h14, 8'h68, v, 8'h79, 8'h80}, 6);
      img[8'h14] = 8'h80;
      run(30, 0);
      chk("R7", "branch sweep pc", pc, want);
      chk("R7", "branch sweep halted", halted, 1);
    end

    summary();
    $finish;
  end

endmodule